// File: doc/BRIEF.md
# ID-addressed device state controller

This block holds the control fields that switch a set of on-chip devices on and off. It also holds the status fields that report what state each device is in. A client names a device by a small logical id and asks for it to be enabled or disabled. The block maps that id through a table of ranges. Each range covers consecutive ids with fields of the same width and has its own register, its own first bit and its own enable and disable codes. The block then rewrites only the addressed field of the right control register and answers one cycle later with accepted or rejected. Some devices cannot be disabled. A disable request aimed at one of them is refused, and so is a request for an id that no range covers. Neither changes any state.

Status fields are held in local registers. The peripherals load them through a status write port that carries an id and a raw code. A combinational query port takes an id and decodes its status field into one of four answers: enabled, disabled, some other code, or no such device. The control registers are driven out as one flat bus so that the logic they steer can use them.

Top module: `devstate_ctrl`

## Requirements
- R1: After synchronous reset, every control and status register reads zero and rsp_valid is 0. A query of any id from 0 to 11 therefore returns disabled (2'b00).
- R2: For an id n from 0 to 11, an accepted enable writes code 1 into the 2-bit field at bits 2n+1:2n of control register 0, and a disable writes code 0 there. Control register 0 is ctl_regs_flat[31:0].
- R3: For id 12, an enable writes code 3 into bits 31:30 of control register 0, and a disable writes code 0 there.
- R4: For id 13 or 14, an enable writes 1 into bit (id-13) of control register 1, which is ctl_regs_flat[63:32]. A disable to either id is rejected and leaves all control registers unchanged.
- R5: A request for id 15 is rejected and leaves all control registers unchanged, whatever the operation.
- R6: rsp_valid is high exactly in the cycle after a cycle with req_valid high. In that cycle rsp_accept tells whether the request was applied (1) or rejected (0). Without a request the control registers hold their value.
- R7: An update changes only the addressed field. All other bits of the same register are kept, including the neighbouring fields.
- R8: A status write stores the 3-bit code for id n from 0 to 9 at bits 3n+2:3n of status register 0, and for id 10 or 11 at bits 3(n-10)+2:3(n-10) of status register 1. Neighbouring status fields are kept. A status write to an id of 12 or more changes no status field.
- R9: query_state decodes the queried status field in the same cycle. A stored code of 1 gives 2'b01 (enabled), 0 gives 2'b00 (disabled), any other code gives 2'b10 (other), and an id of 12 or more gives 2'b11 (no such device).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Control request strobe |
| req_id | input | 4 | Logical device id of the request |
| req_op | input | 1 | 1 = enable, 0 = disable |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_accept | output | 1 | 1 = request applied, 0 = rejected |
| sts_wr_valid | input | 1 | Status field write strobe |
| sts_wr_id | input | 4 | Device id whose status field is written |
| sts_wr_code | input | 3 | Raw status code to store |
| query_id | input | 4 | Device id to report on |
| query_state | output | 2 | 00 disabled, 01 enabled, 10 other, 11 no such device |
| ctl_regs_flat | output | 64 | Control register 1 in [63:32], register 0 in [31:0] |

## Verification
The request path is driven with a cumulative sequence that touches the first, a middle and the last id of the wide-range group, as well as the lone top field with its distinct enable code and the single-bit undisableable pair. Comparing the full register value after every step separates a correct field position from a wrong stride or start bit, and it catches a read-modify-write that damages a neighbour. Rejected patterns (disable of a fixed device, an id outside every range) show whether refusal really leaves state alone, and back-to-back requests show that the response pipeline does not drop or merge strobes. Status writes use codes 0, 1 and values outside both, in both status registers and at an unmapped id, which tells the three-way decode and the range selection apart.

// File: rtl/devstate_pkg.sv
package devstate_pkg;

    localparam int REG_W          = 32;
    localparam int ID_W           = 4;
    localparam int NUM_CTL_REGS   = 2;
    localparam int NUM_STS_REGS   = 2;
    localparam int NUM_CTL_RANGES = 3;
    localparam int NUM_STS_RANGES = 2;
    localparam int STS_CODE_W     = 3;
    localparam int MAX_REGS       = (NUM_CTL_REGS > NUM_STS_REGS) ? NUM_CTL_REGS : NUM_STS_REGS;
    localparam int REG_IDX_W      = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;
    localparam int LSB_W          = $clog2(REG_W);
    localparam int NB_W           = LSB_W + 1;

    typedef logic [ID_W-1:0]  dev_id_t;
    typedef logic [REG_W-1:0] word_t;

    typedef enum logic {
        OP_DISABLE = 1'b0,
        OP_ENABLE  = 1'b1
    } dev_op_e;

    typedef enum logic [1:0] {
        ST_DISABLED = 2'b00,
        ST_ENABLED  = 2'b01,
        ST_OTHER    = 2'b10,
        ST_NO_ID    = 2'b11
    } dev_state_e;

    // One range of identical fields serving consecutive ids.
    typedef struct packed {
        dev_id_t                first_id;
        logic [ID_W:0]          count;
        logic [REG_IDX_W-1:0]   reg_sel;
        word_t                  on_code;
        word_t                  off_code;
        logic [LSB_W-1:0]       base_bit;
        logic [NB_W-1:0]        width;
    } range_t;

    // Resolved location of one device's field.
    typedef struct packed {
        logic                   hit;
        logic [REG_IDX_W-1:0]   reg_sel;
        logic [LSB_W-1:0]       lsb;
        word_t                  mask;
        word_t                  on_code;
        word_t                  off_code;
    } field_t;

    // Off code of all ones marks a device that refuses to be disabled.
    localparam word_t NO_DISABLE = '1;

    localparam range_t CTL_MAP [NUM_CTL_RANGES] = '{
        '{first_id: 4'd0,  count: 5'd12, reg_sel: 1'd0, on_code: 32'd1,
          off_code: 32'd0, base_bit: 5'd0,  width: 6'd2},
        '{first_id: 4'd12, count: 5'd1,  reg_sel: 1'd0, on_code: 32'd3,
          off_code: 32'd0, base_bit: 5'd30, width: 6'd2},
        '{first_id: 4'd13, count: 5'd2,  reg_sel: 1'd1, on_code: 32'd1,
          off_code: NO_DISABLE, base_bit: 5'd0, width: 6'd1}
    };

    localparam range_t STS_MAP [NUM_STS_RANGES] = '{
        '{first_id: 4'd0,  count: 5'd10, reg_sel: 1'd0, on_code: 32'd1,
          off_code: 32'd0, base_bit: 5'd0, width: 6'd3},
        '{first_id: 4'd10, count: 5'd2,  reg_sel: 1'd1, on_code: 32'd1,
          off_code: 32'd0, base_bit: 5'd0, width: 6'd3}
    };

    function automatic word_t field_mask(input logic [NB_W-1:0] width,
                                         input logic [LSB_W-1:0] lsb);
        logic [2*REG_W-1:0] ones;
        ones = ((2*REG_W)'(1) << width) - (2*REG_W)'(1);
        return word_t'(ones << lsb);
    endfunction

    function automatic field_t locate(input range_t r, input dev_id_t id);
        field_t        f;
        logic [ID_W:0] id_x;
        logic [ID_W:0] rel;
        logic [LSB_W+ID_W+1:0] pos;
        id_x       = {1'b0, id};
        rel        = id_x - {1'b0, r.first_id};
        pos        = (LSB_W+ID_W+2)'(r.base_bit) + (LSB_W+ID_W+2)'(rel) * (LSB_W+ID_W+2)'(r.width);
        f.hit      = (id_x >= {1'b0, r.first_id}) && (rel < r.count);
        f.reg_sel  = r.reg_sel;
        f.lsb      = LSB_W'(pos);
        f.mask     = field_mask(r.width, LSB_W'(pos));
        f.on_code  = r.on_code;
        f.off_code = r.off_code;
        return f;
    endfunction

    function automatic field_t ctl_field(input dev_id_t id);
        field_t res;
        field_t cand;
        res = '0;
        for (int i = NUM_CTL_RANGES - 1; i >= 0; i--) begin
            cand = locate(CTL_MAP[i], id);
            if (cand.hit) res = cand;
        end
        return res;
    endfunction

    function automatic field_t sts_field(input dev_id_t id);
        field_t res;
        field_t cand;
        res = '0;
        for (int i = NUM_STS_RANGES - 1; i >= 0; i--) begin
            cand = locate(STS_MAP[i], id);
            if (cand.hit) res = cand;
        end
        return res;
    endfunction

endpackage

// File: rtl/devstate_ctl_bank.sv
module devstate_ctl_bank
    import devstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  dev_id_t req_id,
    input  dev_op_e req_op,
    output logic    rsp_valid,
    output logic    rsp_accept,
    output word_t   regs_o [NUM_CTL_REGS]
);

    field_t fld;
    logic   apply;
    word_t  code;
    word_t  placed;

    always_comb begin
        fld    = ctl_field(req_id);
        apply  = req_valid && fld.hit &&
                 ((req_op == OP_ENABLE) || (fld.off_code != NO_DISABLE));
        code   = (req_op == OP_ENABLE) ? fld.on_code : fld.off_code;
        placed = (code << fld.lsb) & fld.mask;
    end

    for (genvar g = 0; g < NUM_CTL_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[g] <= '0;
            end else if (apply && (fld.reg_sel == REG_IDX_W'(g))) begin
                regs_o[g] <= (regs_o[g] & ~fld.mask) | placed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_accept <= apply;
        end
    end

endmodule

// File: rtl/devstate_sts_bank.sv
module devstate_sts_bank
    import devstate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  dev_id_t               wr_id,
    input  logic [STS_CODE_W-1:0] wr_code,
    input  dev_id_t               q_id,
    output dev_state_e            q_state
);

    word_t  regs [NUM_STS_REGS];
    field_t wfld;
    field_t qfld;
    word_t  wval;
    word_t  qval;

    always_comb begin
        wfld = sts_field(wr_id);
        wval = (word_t'(wr_code) << wfld.lsb) & wfld.mask;
    end

    for (genvar g = 0; g < NUM_STS_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_valid && wfld.hit && (wfld.reg_sel == REG_IDX_W'(g))) begin
                regs[g] <= (regs[g] & ~wfld.mask) | wval;
            end
        end
    end

    always_comb begin
        qfld = sts_field(q_id);
        qval = (regs[qfld.reg_sel] & qfld.mask) >> qfld.lsb;
        if (!qfld.hit)                  q_state = ST_NO_ID;
        else if (qval == qfld.on_code)  q_state = ST_ENABLED;
        else if (qval == qfld.off_code) q_state = ST_DISABLED;
        else                            q_state = ST_OTHER;
    end

endmodule

// File: rtl/devstate_ctrl.sv
module devstate_ctrl
    import devstate_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic [ID_W-1:0]                req_id,
    input  logic                           req_op,
    output logic                           rsp_valid,
    output logic                           rsp_accept,
    input  logic                           sts_wr_valid,
    input  logic [ID_W-1:0]                sts_wr_id,
    input  logic [STS_CODE_W-1:0]          sts_wr_code,
    input  logic [ID_W-1:0]                query_id,
    output logic [1:0]                     query_state,
    output logic [NUM_CTL_REGS*REG_W-1:0]  ctl_regs_flat
);

    word_t      ctl_regs [NUM_CTL_REGS];
    dev_state_e q_state;

    devstate_ctl_bank u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_id     (req_id),
        .req_op     (dev_op_e'(req_op)),
        .rsp_valid  (rsp_valid),
        .rsp_accept (rsp_accept),
        .regs_o     (ctl_regs)
    );

    devstate_sts_bank u_sts (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (sts_wr_valid),
        .wr_id    (sts_wr_id),
        .wr_code  (sts_wr_code),
        .q_id     (query_id),
        .q_state  (q_state)
    );

    assign query_state = q_state;

    for (genvar g = 0; g < NUM_CTL_REGS; g++) begin : g_flat
        assign ctl_regs_flat[g*REG_W +: REG_W] = ctl_regs[g];
    end

endmodule

// File: rtl/devstate_ctrl_chk.sv
module devstate_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [3:0]  req_id,
    input logic        req_op,
    input logic        rsp_valid,
    input logic        rsp_accept,
    input logic [3:0]  query_id,
    input logic [1:0]  query_state,
    input logic [63:0] ctl_regs_flat
);

    // R6: one response strobe per request, one cycle later
    a_r6_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r6_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r6_idle_regs_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(ctl_regs_flat));

    // R5: unmapped id is refused without side effect
    a_r5_unmapped_rejected: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_id == 4'd15) |=> (!rsp_accept && $stable(ctl_regs_flat)));

    // R4: fixed devices refuse disable
    a_r4_fixed_no_disable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op && (req_id == 4'd13 || req_id == 4'd14))
        |=> (!rsp_accept && $stable(ctl_regs_flat)));

    // R3: id 12 enable lands code 3 at the top of register 0
    a_r3_top_field_enable: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && req_id == 4'd12)
        |=> (rsp_accept && ctl_regs_flat[31:30] == 2'b11));

    // R9: ids beyond the status map report no such device
    a_r9_unmapped_query: assert property (@(posedge clk) disable iff (rst)
        (query_id >= 4'd12) |-> (query_state == 2'b11));

endmodule

bind devstate_ctrl devstate_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_id        (req_id),
    .req_op        (req_op),
    .rsp_valid     (rsp_valid),
    .rsp_accept    (rsp_accept),
    .query_id      (query_id),
    .query_state   (query_state),
    .ctl_regs_flat (ctl_regs_flat)
);

// File: tb/devstate_ctrl_bench.sv
`timescale 1ns/1ps
module devstate_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_id = '0;
    logic        req_op = 1'b0;
    logic        rsp_valid;
    logic        rsp_accept;
    logic        sts_wr_valid = 1'b0;
    logic [3:0]  sts_wr_id = '0;
    logic [2:0]  sts_wr_code = '0;
    logic [3:0]  query_id = '0;
    logic [1:0]  query_state;
    logic [63:0] ctl_regs_flat;

    int n_checks = 0;
    int n_fails  = 0;
    logic [1:0] exp_st [12];

    always #2 clk = ~clk;

    devstate_ctrl u_devstate_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_op(req_op),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .sts_wr_valid(sts_wr_valid),
        .sts_wr_id(sts_wr_id), .sts_wr_code(sts_wr_code), .query_id(query_id),
        .query_state(query_state), .ctl_regs_flat(ctl_regs_flat)
    );

    typedef struct packed {
        logic [3:0]  id;
        logic        op;
        logic        acc;
        logic [31:0] r0;
        logic [31:0] r1;
    } vec_t;

    localparam int NV = 13;
    // Cumulative from reset; expected register values after each request.
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1, 1'b1, 32'h0000_0001, 32'h0},  // R2 first id
        '{4'd5,  1'b1, 1'b1, 32'h0000_0401, 32'h0},  // R2 R7 middle id
        '{4'd11, 1'b1, 1'b1, 32'h0040_0401, 32'h0},  // R2 last id
        '{4'd12, 1'b1, 1'b1, 32'hC040_0401, 32'h0},  // R3
        '{4'd5,  1'b0, 1'b1, 32'hC040_0001, 32'h0},  // R2 R7 disable
        '{4'd13, 1'b1, 1'b1, 32'hC040_0001, 32'h1},  // R4
        '{4'd14, 1'b1, 1'b1, 32'hC040_0001, 32'h3},  // R4 R7
        '{4'd13, 1'b0, 1'b0, 32'hC040_0001, 32'h3},  // R4 refused
        '{4'd15, 1'b1, 1'b0, 32'hC040_0001, 32'h3},  // R5
        '{4'd12, 1'b0, 1'b1, 32'h0040_0001, 32'h3},  // R3 disable
        '{4'd0,  1'b0, 1'b1, 32'h0040_0000, 32'h3},  // R2 R7
        '{4'd11, 1'b1, 1'b1, 32'h0040_0000, 32'h3},  // R2 repeat enable
        '{4'd15, 1'b0, 1'b0, 32'h0040_0000, 32'h3}   // R5 disable op
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sts_write(input logic [3:0] id, input logic [2:0] code);
        @(negedge clk);
        sts_wr_valid = 1'b1; sts_wr_id = id; sts_wr_code = code;
        @(negedge clk);
        sts_wr_valid = 1'b0;
    endtask

    task automatic check_all_states(input string tag);
        for (int i = 0; i < 12; i++) begin
            query_id = 4'(i);
            #1;
            chk(tag, 64'(query_state), 64'(exp_st[i]));
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) exp_st[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl regs", ctl_regs_flat, 64'h0);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
        check_all_states("R1 status after reset");
        for (int i = 12; i < 16; i++) begin
            query_id = 4'(i);
            #1;
            chk("R9 unmapped query", 64'(query_state), 64'h3);
        end

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            req_valid = 1'b1; req_id = VECS[v].id; req_op = VECS[v].op;
            @(negedge clk);
            chk("R6 rsp_valid", 64'(rsp_valid), 64'h1);
            chk("R6 rsp_accept", 64'(rsp_accept), 64'(VECS[v].acc));
            chk("R7 ctl reg0", 64'(ctl_regs_flat[31:0]), 64'(VECS[v].r0));
            chk("R4 ctl reg1", 64'(ctl_regs_flat[63:32]), 64'(VECS[v].r1));
            req_valid = 1'b0;
            @(negedge clk);
            chk("R6 rsp drops", 64'(rsp_valid), 64'h0);
        end

        // R6 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_id = 4'd1; req_op = 1'b1;
        @(negedge clk);
        chk("R6 b2b first accept", 64'(rsp_accept & rsp_valid), 64'h1);
        chk("R7 b2b first reg0", 64'(ctl_regs_flat[31:0]), 64'h0040_0004);
        req_id = 4'd2;
        @(negedge clk);
        chk("R6 b2b second valid", 64'(rsp_valid), 64'h1);
        chk("R7 b2b second reg0", 64'(ctl_regs_flat[31:0]), 64'h0040_0014);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R6 b2b idle", 64'(rsp_valid), 64'h0);
        chk("R6 idle hold", ctl_regs_flat, 64'h0000_0003_0040_0014);

        // R8 / R9 status writes and decode
        sts_write(4'd3, 3'd1);  exp_st[3]  = 2'b01;
        check_all_states("R8 R9 id3 enabled");
        sts_write(4'd9, 3'd5);  exp_st[9]  = 2'b10;
        sts_write(4'd10, 3'd1); exp_st[10] = 2'b01;
        sts_write(4'd11, 3'd7); exp_st[11] = 2'b10;
        check_all_states("R8 R9 mixed codes");
        sts_write(4'd4, 3'd2);  exp_st[4]  = 2'b10;
        check_all_states("R8 neighbour kept");
        sts_write(4'd12, 3'd1);
        sts_write(4'd15, 3'd6);
        check_all_states("R8 unmapped write ignored");
        sts_write(4'd9, 3'd0);  exp_st[9]  = 2'b00;
        sts_write(4'd3, 3'd0);  exp_st[3]  = 2'b00;
        check_all_states("R9 back to disabled");
        chk("R8 status leaves ctl", ctl_regs_flat, 64'h0000_0003_0040_0014);

        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) exp_st[i] = 2'b00;
        #1;
        chk("R1 ctl after re-reset", ctl_regs_flat, 64'h0);
        check_all_states("R1 status after re-reset");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule